// File: doc/BRIEF.md
# Receive starvation backoff scheduler

This block sits next to a receive channel scheduler. When a receive channel runs out of free descriptors or buffers, the scheduler reports a starvation event for that channel. The event carries a flag that says whether the channel's flow keeps its packets on error instead of dropping them. For a keeping flow, the block holds the channel out of scheduling for a programmable number of clock cycles. After that the channel becomes eligible again and can recheck its free queue. The point of the wait is that the engine does not spend schedule slots on channels that cannot make progress.

A single 16-bit backoff count sets the length of the wait. Software can write and read it, and it resets to 0x40. A count of zero turns the backoff off. A starvation event on a flow that drops packets never delays its channel. Each channel has its own down-counter. The count is captured when the event arrives, so a later write only changes events that arrive after it. Arbitration among the eligible channels happens outside this block.

Top module: `rx_backoff_sched`

## Requirements
- R1: After a synchronous reset, every bit of `eligible` is 1 and `cfg_rd_data` reads 0x0040.
- R2: A cycle with `cfg_wr_en` high loads `cfg_wr_data` into the backoff count, and `cfg_rd_data` shows it from the next cycle. With `cfg_wr_en` low, the count does not change.
- R3: A starvation event on channel c drives `eligible[c]` to 0 from the next cycle when both of these hold: `starve_keep[c]` is 1 (the flow keeps packets) and the count is nonzero.
- R4: A channel held this way stays ineligible for exactly N cycles, where N is the count captured with its event, and then returns to 1. This meets the guarantee that the wait is at least N cycles.
- R5: A starvation event with `starve_keep[c]` at 0 leaves `eligible[c]` at 1 in the next cycle. This holds even if channel c was already held by an earlier event.
- R6: While the count is 0, a starvation event with `starve_keep[c]` at 1 leaves `eligible[c]` at 1 in the next cycle.
- R7: A running wait uses the count that was in effect when its event arrived. A count write in the same cycle as the event, or in any later cycle, does not change that wait.
- R8: A new keeping event on a channel that is already held restarts its wait with the current count.
- R9: Channels are independent. Events on one channel never change the `eligible` bit of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the backoff count |
| cfg_wr_data | input | 16 | New backoff count |
| cfg_rd_data | output | 16 | Current backoff count |
| starve_valid | input | NUM_CH | Per-channel starvation event, one cycle per event |
| starve_keep | input | NUM_CH | Per-channel flag: the flow keeps packets on error |
| eligible | output | NUM_CH | Per-channel permission to be scheduled |

## Verification
The bench first sends single keeping events at small counts. This shows whether the hold lasts exactly N cycles or is off by one cycle in either direction. It then pairs events with count writes, dropping-flow events and zero counts, and hits one channel again while it is still held. These cases separate a count that is captured at the event from one that is read live, and a timer that restarts from one that does not. A final stretch of random events and occasional writes across all channels is compared cycle by cycle against a behavioural model. That stretch exposes any crosstalk between channels and any wrong priority when an event and the end of a wait meet in the same cycle.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    // Action a channel timer takes on a given cycle
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,  // no event: keep counting down
        ACT_ARM     = 2'd1,  // keeping flow, nonzero count: start a hold
        ACT_RELEASE = 2'd2   // dropping flow or count zero: eligible at once
    } starve_action_e;

    localparam int unsigned DEF_CNT_W   = 16;
    localparam logic [15:0] DEF_BACKOFF = 16'h0040;

    function automatic starve_action_e decode_action(input logic ev_valid,
                                                     input logic ev_keep,
                                                     input logic cnt_zero);
        if (!ev_valid)
            return ACT_NONE;
        else if (ev_keep && !cnt_zero)
            return ACT_ARM;
        else
            return ACT_RELEASE;
    endfunction

endpackage

// File: rtl/rbs_cfg_reg.sv
module rbs_cfg_reg #(
    parameter int unsigned      CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = 16'h0040
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= RST_VAL;
        else if (wr_en)
            count_q <= wr_data;
    end

    assign count = count_q;

endmodule

// File: rtl/rbs_chan_timer.sv
module rbs_chan_timer
    import rbs_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_valid,
    input  logic             ev_keep,
    input  logic [CNT_W-1:0] load_val,
    output logic             eligible
);

    typedef struct packed {
        logic             blocked;
        logic [CNT_W-1:0] remain;
    } chan_state_t;

    chan_state_t    cur_q, nxt;
    starve_action_e act;

    assign act = decode_action(ev_valid, ev_keep, (load_val == '0));

    always_comb begin
        nxt = cur_q;
        unique case (act)
            ACT_ARM: begin
                nxt.blocked = 1'b1;
                nxt.remain  = load_val;
            end
            ACT_RELEASE: begin
                nxt.blocked = 1'b0;
                nxt.remain  = '0;
            end
            default: begin
                if (cur_q.blocked) begin
                    if (cur_q.remain <= CNT_W'(1)) begin
                        nxt.blocked = 1'b0;
                        nxt.remain  = '0;
                    end else begin
                        nxt.remain = cur_q.remain - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else
            cur_q <= nxt;
    end

    assign eligible = ~cur_q.blocked;

endmodule

// File: rtl/rx_backoff_sched.sv
module rx_backoff_sched
    import rbs_pkg::*;
#(
    parameter int unsigned      NUM_CH  = 8,
    parameter int unsigned      CNT_W   = DEF_CNT_W,
    parameter logic [CNT_W-1:0] RST_CNT = DEF_BACKOFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CNT_W-1:0]  cfg_wr_data,
    output logic [CNT_W-1:0]  cfg_rd_data,
    input  logic [NUM_CH-1:0] starve_valid,
    input  logic [NUM_CH-1:0] starve_keep,
    output logic [NUM_CH-1:0] eligible
);

    logic [CNT_W-1:0] backoff_cnt;

    rbs_cfg_reg #(
        .CNT_W  (CNT_W),
        .RST_VAL(RST_CNT)
    ) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_wr_en),
        .wr_data(cfg_wr_data),
        .count  (backoff_cnt)
    );

    assign cfg_rd_data = backoff_cnt;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        rbs_chan_timer #(
            .CNT_W(CNT_W)
        ) tmr_i (
            .clk     (clk),
            .rst     (rst),
            .ev_valid(starve_valid[c]),
            .ev_keep (starve_keep[c]),
            .load_val(backoff_cnt),
            .eligible(eligible[c])
        );
    end

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int unsigned      NUM_CH  = 8,
    parameter int unsigned      CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_CNT = 16'h0040
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr_en,
    input logic [CNT_W-1:0]  cfg_rd_data,
    input logic [NUM_CH-1:0] starve_valid,
    input logic [NUM_CH-1:0] starve_keep,
    input logic [NUM_CH-1:0] eligible
);

    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RESET_STATE: assert (eligible == '1 && cfg_rd_data == RST_CNT); // R1
        end
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> $stable(cfg_rd_data)); // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        logic [31:0]      elap_q;
        logic [CNT_W-1:0] need_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                elap_q <= '0;
                need_q <= '0;
            end else if (starve_valid[c]) begin
                elap_q <= '0;
                need_q <= (starve_keep[c] && cfg_rd_data != '0) ? cfg_rd_data : '0;
            end else if (elap_q != 32'hFFFF_FFFF) begin
                elap_q <= elap_q + 32'd1;
            end
        end

        AST_HOLD_ON_KEEP: assert property (@(posedge clk) disable iff (rst)
            starve_valid[c] && starve_keep[c] && cfg_rd_data != '0 |=> !eligible[c]); // R3

        AST_MIN_WAIT: assert property (@(posedge clk) disable iff (rst)
            $rose(eligible[c]) |-> elap_q >= 32'(need_q)); // R4

        AST_DROP_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
            starve_valid[c] && !starve_keep[c] |=> eligible[c]); // R5

        AST_ZERO_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
            starve_valid[c] && cfg_rd_data == '0 |=> eligible[c]); // R6

        AST_IDLE_NO_FALL: assert property (@(posedge clk) disable iff (rst)
            !starve_valid[c] |=> !$fell(eligible[c])); // R9
    end

endmodule

bind rx_backoff_sched rbs_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .RST_CNT(RST_CNT)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_rd_data (cfg_rd_data),
    .starve_valid(starve_valid),
    .starve_keep (starve_keep),
    .eligible    (eligible)
);

// File: tb/rx_backoff_sched_tb_top.sv
`timescale 1ns/1ps
module rx_backoff_sched_tb_top;

    localparam int NCH = 8;
    localparam int CW  = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_wr_en = 1'b0;
    logic [CW-1:0]  cfg_wr_data = '0;
    logic [CW-1:0]  cfg_rd_data;
    logic [NCH-1:0] starve_valid = '0;
    logic [NCH-1:0] starve_keep = '0;
    logic [NCH-1:0] eligible;

    always #2.5 clk = ~clk;

    rx_backoff_sched #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .starve_valid(starve_valid), .starve_keep(starve_keep), .eligible(eligible)
    );

    // Behavioural reference: remaining hold cycles per channel and the count
    int    m_rem [NCH];
    int    m_cnt;
    bit    m_ok = 0;
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string phase = "R1";

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            foreach (m_rem[c]) m_rem[c] = 0;
            m_cnt = 'h40;
        end else begin
            foreach (m_rem[c]) begin
                if (starve_valid[c])
                    m_rem[c] = (starve_keep[c] && m_cnt != 0) ? m_cnt : 0;
                else if (m_rem[c] > 0)
                    m_rem[c] = m_rem[c] - 1;
            end
            if (cfg_wr_en) m_cnt = int'(cfg_wr_data);
        end
        m_ok = 1;
    end

    always @(negedge clk) begin
        if (m_ok) begin
            logic [NCH-1:0] exp_el;
            foreach (m_rem[c]) exp_el[c] = (m_rem[c] == 0);
            checks++;
            if (eligible !== exp_el) begin
                errors++;
                $display("FAIL %s: eligible=%b expected %b at cycle %0d", phase, eligible, exp_el, cyc);
            end
            checks++;
            if (cfg_rd_data !== CW'(m_cnt)) begin
                errors++;
                $display("FAIL %s: count=%h expected %h at cycle %0d", phase, cfg_rd_data, CW'(m_cnt), cyc);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: cycle=%0d expected completion before 150000", cyc);
            finish_run();
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drive(input logic [NCH-1:0] v, input logic [NCH-1:0] k,
                         input bit we, input logic [CW-1:0] wd);
        starve_valid = v; starve_keep = k; cfg_wr_en = we; cfg_wr_data = wd;
        @(posedge clk); #1;
        starve_valid = '0; starve_keep = '0; cfg_wr_en = 1'b0;
    endtask

    initial begin
        phase = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);

        phase = "R2";
        drive('0, '0, 1, 16'd5);
        idle(2);
        drive('0, '0, 1, 16'd3);
        idle(2);

        phase = "R3";                 // hold of 3 cycles on channel 0
        drive(8'h01, 8'h01, 0, '0);
        phase = "R4";
        idle(5);
        drive('0, '0, 1, 16'd1);      // shortest nonzero hold
        drive(8'h01, 8'h01, 0, '0);
        idle(3);

        phase = "R5";
        drive('0, '0, 1, 16'd6);
        drive(8'h02, 8'h02, 0, '0);
        idle(2);
        drive(8'h02, 8'h00, 0, '0);   // dropping flow releases a held channel
        idle(2);

        phase = "R6";
        drive('0, '0, 1, 16'd0);
        drive(8'h04, 8'h04, 0, '0);
        idle(3);

        phase = "R7";
        drive('0, '0, 1, 16'd10);
        drive(8'h08, 8'h08, 1, 16'd2); // write in same cycle as event
        idle(3);
        drive('0, '0, 1, 16'd0);       // later write, wait unchanged
        idle(10);

        phase = "R8";
        drive('0, '0, 1, 16'd5);
        drive(8'h10, 8'h10, 0, '0);
        idle(3);
        drive(8'h10, 8'h10, 1, 16'd7);
        idle(8);
        drive(8'h10, 8'h10, 0, '0);
        idle(9);

        phase = "R9";
        drive(8'hA5, 8'h85, 0, '0);
        idle(4);
        drive(8'h5A, 8'hFF, 0, '0);
        idle(9);
        for (int i = 0; i < 2000; i++) begin
            logic [NCH-1:0] v, k;
            v = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            k = NCH'($urandom);
            if (($urandom % 16) == 0)
                drive(v, k, 1, CW'($urandom % 12));
            else
                drive(v, k, 0, '0);
        end

        phase = "R4";                  // a longer hold
        drive('0, '0, 1, 16'd300);
        drive(8'h80, 8'h80, 0, '0);
        idle(305);

        phase = "R1";                  // reset in mid hold
        drive(8'h01, 8'h01, 0, '0);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(3);

        finish_run();
    end

endmodule